// File: doc/BRIEF.md
# HDMI Data Island Framer

This block produces the three 10-bit TMDS lane symbols for one data island inside horizontal blanking. It sends a preamble and a leading guard band. Two packets follow as TERC4 symbols, each 32 pixels long. A trailing guard band comes next, and the lanes then go back to control symbols. The video timing logic supplies the live sync levels and a count of blanking pixels still left on the line. A packet source supplies the header bits and subpacket bits of both packets. The source raises a request when an island should be sent.

Nothing is latched until a request is accepted. Acceptance needs an idle framer and enough blanking room left for the full island of 76 pixels. A request that arrives without room is held and taken on a later line. At acceptance the header and body of both packets are copied in, so the source may change its inputs while the island is on the wire. Blue carries HSYNC and VSYNC in every phase. These bits come straight from the live inputs, with no register stage, so sync edges line up with the rest of the video path. The first packet slot is meant for info frames or clock-regeneration packets. The second slot is meant for audio samples.

Top module: `hdmi_island_framer`

## Requirements
- R1: While idle, `busy` is 0, red and green both carry 1101010100, and blue carries the control symbol for (c1=vsync, c0=hsync): 00→1101010100, 01→0010101011, 10→0101010100, 11→1010101011.
- R2: Island pixels 0 to 7 form the preamble. Red and green both carry 0010101011, and blue carries the R1 control symbol for the current sync levels.
- R3: Island pixels 8 and 9 form the leading guard band. Red and green both carry 0100110011, and blue carries the TERC4 code of the nibble {1,1,vsync,hsync}.
- R4: Island pixels 10 to 73 carry packet p=(i-10)/32 at position k=(i-10)%32. Blue carries the TERC4 code of {b3, header bit, vsync, hsync}. b3 is 0 when k=0 and 1 otherwise. The header bit is `pkt_header[p*32+k]`.
- R5: Subpacket s of packet p is `pkt_body[(p*4+s)*64 +: 64]`. At position k, green carries the TERC4 code of {sp1[2k+1], sp1[2k], sp0[2k+1], sp0[2k]}. Red carries the same arrangement taken from sp3 and sp2.
- R6: Island pixels 74 and 75 form the trailing guard band, coded as in R3. `busy` is 1 for exactly 76 cycles, from the cycle after acceptance. The next cycle is idle, as in R1.
- R7: A request is accepted at a clock edge where the framer is idle and `blank_left` is at least 76. A request seen without that room is held and accepted at the first later edge that meets the condition, even after `island_req` has dropped.
- R8: During every phase, the sync bits on blue follow `hsync` and `vsync` in the same cycle, with no register delay.
- R9: Header and body bits are captured at acceptance. Changes on `pkt_header` and `pkt_body` during the island do not alter the symbols sent.
- R10: TERC4 codes for nibbles 0 to F are 1010011100, 1001100011, 1011100100, 1011100010, 0101110001, 0100011110, 0110001110, 0100111100, 1011001100, 0100111001, 0110011100, 1011000110, 1010001110, 1001110001, 0101100011, 1011000011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| island_req | input | 1 | Request to send one island |
| hsync | input | 1 | Live horizontal sync level |
| vsync | input | 1 | Live vertical sync level |
| blank_left | input | 12 | Blanking pixels still left on this line |
| pkt_header | input | 64 | 32 header bits per packet, packet 0 in the low bits |
| pkt_body | input | 512 | Four 64-bit subpackets per packet |
| lane_b | output | 10 | Channel 0 (blue) symbol |
| lane_g | output | 10 | Channel 1 (green) symbol |
| lane_r | output | 10 | Channel 2 (red) symbol |
| busy | output | 1 | High while an island is being sent |

## Verification
The hardest case to reach is a request that arrives without enough blanking room and must still launch later, after the request line has already dropped. The bench reaches it with a directed sequence. It pulses the request while `blank_left` is one pixel short and holds the framer idle for several cycles. It then raises the room to exactly 76 with no request present. Random islands drive new sync levels and new packet inputs on every pixel. This exercises the sync bits on blue in every phase and checks that the captured packet is not disturbed.

// File: rtl/hdmi_isl_pkg.sv
package hdmi_isl_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_PRE,
      PH_LGUARD,
      PH_DATA,
      PH_TGUARD
   } phase_t;

   localparam logic [9:0] SYM_GUARD_RG = 10'b0100110011;

   // R10: 4-bit to 10-bit code used for island payload and guard on blue
   function automatic logic [9:0] terc4_sym(input logic [3:0] d);
      logic [9:0] s;
      case (d)
         4'h0: s = 10'b1010011100;
         4'h1: s = 10'b1001100011;
         4'h2: s = 10'b1011100100;
         4'h3: s = 10'b1011100010;
         4'h4: s = 10'b0101110001;
         4'h5: s = 10'b0100011110;
         4'h6: s = 10'b0110001110;
         4'h7: s = 10'b0100111100;
         4'h8: s = 10'b1011001100;
         4'h9: s = 10'b0100111001;
         4'hA: s = 10'b0110011100;
         4'hB: s = 10'b1011000110;
         4'hC: s = 10'b1010001110;
         4'hD: s = 10'b1001110001;
         4'hE: s = 10'b0101100011;
         default: s = 10'b1011000011;
      endcase
      return s;
   endfunction

   // control symbols indexed {c1,c0}
   function automatic logic [9:0] ctrl_sym(input logic [1:0] c);
      logic [9:0] s;
      case (c)
         2'b00: s = 10'b1101010100;
         2'b01: s = 10'b0010101011;
         2'b10: s = 10'b0101010100;
         default: s = 10'b1010101011;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/hdmi_isl_seq.sv
module hdmi_isl_seq
   import hdmi_isl_pkg::*;
#(
   parameter int PREAMBLE_LEN = 8,
   parameter int GUARD_LEN    = 2,
   parameter int DATA_LEN     = 64,
   parameter int DW           = 6,
   parameter int BLANK_W      = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req,
   input  logic [BLANK_W-1:0] blank_left,
   output phase_t             phase,
   output logic [DW-1:0]      data_idx,
   output logic               load
);

   localparam int ISL_LEN = PREAMBLE_LEN + 2 * GUARD_LEN + DATA_LEN;
   localparam int CNT_W   = $clog2(ISL_LEN) + 1;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last_cnt;
   logic             pending;
   phase_t           nxt_phase;

   always_comb begin
      case (phase)
         PH_PRE: begin
            last_cnt  = CNT_W'(PREAMBLE_LEN - 1);
            nxt_phase = PH_LGUARD;
         end
         PH_LGUARD: begin
            last_cnt  = CNT_W'(GUARD_LEN - 1);
            nxt_phase = PH_DATA;
         end
         PH_DATA: begin
            last_cnt  = CNT_W'(DATA_LEN - 1);
            nxt_phase = PH_TGUARD;
         end
         PH_TGUARD: begin
            last_cnt  = CNT_W'(GUARD_LEN - 1);
            nxt_phase = PH_IDLE;
         end
         default: begin
            last_cnt  = '0;
            nxt_phase = PH_IDLE;
         end
      endcase
   end

   assign load = (phase == PH_IDLE) && (req || pending) &&
                 (blank_left >= BLANK_W'(ISL_LEN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
      end else if (load) begin
         pending <= 1'b0;
      end else if (req) begin
         pending <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else if (load) begin
         phase <= PH_PRE;
         cnt   <= '0;
      end else if (phase != PH_IDLE) begin
         if (cnt == last_cnt) begin
            phase <= nxt_phase;
            cnt   <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign data_idx = cnt[DW-1:0];

endmodule

// File: rtl/hdmi_isl_payload.sv
module hdmi_isl_payload #(
   parameter int N_PKTS     = 2,
   parameter int PKT_PIXELS = 32,
   parameter int N_SUB      = 4,
   parameter int PW         = $clog2(PKT_PIXELS),
   parameter int DW         = PW + $clog2(N_PKTS)
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               load,
   input  logic [N_PKTS*PKT_PIXELS-1:0]       hdr_in,
   input  logic [N_PKTS*N_SUB*2*PKT_PIXELS-1:0] body_in,
   input  logic [DW-1:0]                      data_idx,
   output logic                               hdr_bit,
   output logic                               first_px,
   output logic [3:0]                         nib_g,
   output logic [3:0]                         nib_r
);

   localparam int SP_W = 2 * PKT_PIXELS;

   logic [PKT_PIXELS-1:0] hdr_q [N_PKTS];
   logic [SP_W-1:0]       sp_q  [N_PKTS][N_SUB];

   for (genvar p = 0; p < N_PKTS; p++) begin : g_pkt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hdr_q[p] <= '0;
         end else if (load) begin
            hdr_q[p] <= hdr_in[p*PKT_PIXELS +: PKT_PIXELS];
         end
      end
      for (genvar s = 0; s < N_SUB; s++) begin : g_sub
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sp_q[p][s] <= '0;
            end else if (load) begin
               sp_q[p][s] <= body_in[(p*N_SUB+s)*SP_W +: SP_W];
            end
         end
      end
   end

   logic [PW-1:0]    pix;
   logic [DW-PW-1:0] pk;

   assign pix = data_idx[PW-1:0];
   assign pk  = data_idx[DW-1:PW];

   assign hdr_bit  = hdr_q[pk][pix];
   assign first_px = (pix == '0);
   assign nib_g    = {sp_q[pk][1][{pix, 1'b1}], sp_q[pk][1][{pix, 1'b0}],
                      sp_q[pk][0][{pix, 1'b1}], sp_q[pk][0][{pix, 1'b0}]};
   assign nib_r    = {sp_q[pk][3][{pix, 1'b1}], sp_q[pk][3][{pix, 1'b0}],
                      sp_q[pk][2][{pix, 1'b1}], sp_q[pk][2][{pix, 1'b0}]};

endmodule

// File: rtl/hdmi_isl_symbols.sv
module hdmi_isl_symbols
   import hdmi_isl_pkg::*;
(
   input  phase_t     phase,
   input  logic       hsync,
   input  logic       vsync,
   input  logic       hdr_bit,
   input  logic       first_px,
   input  logic [3:0] nib_g,
   input  logic [3:0] nib_r,
   output logic [9:0] sym_b,
   output logic [9:0] sym_g,
   output logic [9:0] sym_r
);

   logic [1:0] sync_pair;
   assign sync_pair = {vsync, hsync};

   always_comb begin
      case (phase)
         PH_PRE: begin
            sym_r = ctrl_sym(2'b01);
            sym_g = ctrl_sym(2'b01);
            sym_b = ctrl_sym(sync_pair);
         end
         PH_LGUARD, PH_TGUARD: begin
            sym_r = SYM_GUARD_RG;
            sym_g = SYM_GUARD_RG;
            sym_b = terc4_sym({2'b11, sync_pair});
         end
         PH_DATA: begin
            sym_r = terc4_sym(nib_r);
            sym_g = terc4_sym(nib_g);
            sym_b = terc4_sym({~first_px, hdr_bit, sync_pair});
         end
         default: begin
            sym_r = ctrl_sym(2'b00);
            sym_g = ctrl_sym(2'b00);
            sym_b = ctrl_sym(sync_pair);
         end
      endcase
   end

endmodule

// File: rtl/hdmi_island_framer.sv
module hdmi_island_framer
   import hdmi_isl_pkg::*;
#(
   parameter int N_PKTS       = 2,
   parameter int PKT_PIXELS   = 32,
   parameter int PREAMBLE_LEN = 8,
   parameter int GUARD_LEN    = 2,
   parameter int BLANK_W      = 12
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                island_req,
   input  logic                                hsync,
   input  logic                                vsync,
   input  logic [BLANK_W-1:0]                  blank_left,
   input  logic [N_PKTS*PKT_PIXELS-1:0]        pkt_header,
   input  logic [N_PKTS*4*2*PKT_PIXELS-1:0]    pkt_body,
   output logic [9:0]                          lane_b,
   output logic [9:0]                          lane_g,
   output logic [9:0]                          lane_r,
   output logic                                busy
);

   localparam int N_SUB    = 4;
   localparam int DATA_LEN = N_PKTS * PKT_PIXELS;
   localparam int ISL_LEN  = PREAMBLE_LEN + 2 * GUARD_LEN + DATA_LEN;
   localparam int PW       = $clog2(PKT_PIXELS);
   localparam int DW       = PW + $clog2(N_PKTS);

   if (N_PKTS < 2 || (N_PKTS & (N_PKTS - 1)) != 0) begin : g_bad_npkts
      $error("N_PKTS must be a power of two, at least 2");
   end
   if (PKT_PIXELS < 2 || (PKT_PIXELS & (PKT_PIXELS - 1)) != 0) begin : g_bad_pix
      $error("PKT_PIXELS must be a power of two");
   end
   if (PREAMBLE_LEN < 1 || GUARD_LEN < 1) begin : g_bad_len
      $error("preamble and guard lengths must be positive");
   end
   if (ISL_LEN >= (1 << BLANK_W)) begin : g_bad_blank
      $error("BLANK_W too narrow for the island length");
   end

   phase_t        phase;
   logic [DW-1:0] data_idx;
   logic          load;
   logic          hdr_bit;
   logic          first_px;
   logic [3:0]    nib_g;
   logic [3:0]    nib_r;

   hdmi_isl_seq #(
      .PREAMBLE_LEN (PREAMBLE_LEN),
      .GUARD_LEN    (GUARD_LEN),
      .DATA_LEN     (DATA_LEN),
      .DW           (DW),
      .BLANK_W      (BLANK_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (island_req),
      .blank_left (blank_left),
      .phase      (phase),
      .data_idx   (data_idx),
      .load       (load)
   );

   hdmi_isl_payload #(
      .N_PKTS     (N_PKTS),
      .PKT_PIXELS (PKT_PIXELS),
      .N_SUB      (N_SUB),
      .PW         (PW),
      .DW         (DW)
   ) u_payload (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .hdr_in   (pkt_header),
      .body_in  (pkt_body),
      .data_idx (data_idx),
      .hdr_bit  (hdr_bit),
      .first_px (first_px),
      .nib_g    (nib_g),
      .nib_r    (nib_r)
   );

   hdmi_isl_symbols u_sym (
      .phase    (phase),
      .hsync    (hsync),
      .vsync    (vsync),
      .hdr_bit  (hdr_bit),
      .first_px (first_px),
      .nib_g    (nib_g),
      .nib_r    (nib_r),
      .sym_b    (lane_b),
      .sym_g    (lane_g),
      .sym_r    (lane_r)
   );

   assign busy = (phase != PH_IDLE);

endmodule

// File: rtl/hdmi_island_framer_chk.sv
module hdmi_island_framer_chk #(
   parameter int ISL_LEN = 76,
   parameter int BLANK_W = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               island_req,
   input logic               hsync,
   input logic               vsync,
   input logic [BLANK_W-1:0] blank_left,
   input logic [9:0]         lane_b,
   input logic [9:0]         lane_g,
   input logic [9:0]         lane_r,
   input logic               busy
);

   localparam int RL_W = $clog2(ISL_LEN) + 2;

   logic [RL_W-1:0] run_len;
   logic [9:0]      exp_ctl_b;
   logic [9:0]      exp_grd_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_len <= '0;
      else if (busy) run_len <= run_len + 1'b1;
      else run_len <= '0;
   end

   always_comb begin
      case ({vsync, hsync})
         2'b00: begin exp_ctl_b = 10'b1101010100; exp_grd_b = 10'b1010001110; end
         2'b01: begin exp_ctl_b = 10'b0010101011; exp_grd_b = 10'b1001110001; end
         2'b10: begin exp_ctl_b = 10'b0101010100; exp_grd_b = 10'b0101100011; end
         default: begin exp_ctl_b = 10'b1010101011; exp_grd_b = 10'b1011000011; end
      endcase
   end

   p_idle_rg_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (lane_r == 10'b1101010100 && lane_g == 10'b1101010100));

   p_idle_blue_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> lane_b == exp_ctl_b);

   p_guard_blue_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && lane_r == 10'b0100110011) |-> (lane_g == 10'b0100110011 && lane_b == exp_grd_b));

   p_room_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(blank_left) >= BLANK_W'(ISL_LEN));

   p_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && island_req && blank_left >= BLANK_W'(ISL_LEN)) |=> busy);

   p_len_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> run_len < RL_W'(ISL_LEN));

   p_len_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> run_len == RL_W'(ISL_LEN));

endmodule

bind hdmi_island_framer hdmi_island_framer_chk #(
   .ISL_LEN (ISL_LEN),
   .BLANK_W (BLANK_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .island_req (island_req),
   .hsync      (hsync),
   .vsync      (vsync),
   .blank_left (blank_left),
   .lane_b     (lane_b),
   .lane_g     (lane_g),
   .lane_r     (lane_r),
   .busy       (busy)
);

// File: tb/hdmi_island_framer_test.sv
module hdmi_island_framer_test;

   localparam int CLK_PERIOD = 10;
   localparam int ISL        = 76;
   localparam int NRAND      = 24;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         island_req = 1'b0;
   logic         hsync = 1'b0;
   logic         vsync = 1'b0;
   logic [11:0]  blank_left = '0;
   logic [63:0]  pkt_header = '0;
   logic [511:0] pkt_body = '0;
   logic [9:0]   lane_b, lane_g, lane_r;
   logic         busy;

   logic [63:0]  exp_hdr;
   logic [511:0] exp_body;

   int n_checks = 0;
   int n_err    = 0;
   int cyc      = 0;
   bit done     = 1'b0;

   hdmi_island_framer uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .island_req (island_req),
      .hsync      (hsync),
      .vsync      (vsync),
      .blank_left (blank_left),
      .pkt_header (pkt_header),
      .pkt_body   (pkt_body),
      .lane_b     (lane_b),
      .lane_g     (lane_g),
      .lane_r     (lane_r),
      .busy       (busy)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // R10 table, written from the requirement
   function automatic logic [9:0] ref_terc4(input logic [3:0] d);
      logic [9:0] t [16];
      t = '{10'b1010011100, 10'b1001100011, 10'b1011100100, 10'b1011100010,
            10'b0101110001, 10'b0100011110, 10'b0110001110, 10'b0100111100,
            10'b1011001100, 10'b0100111001, 10'b0110011100, 10'b1011000110,
            10'b1010001110, 10'b1001110001, 10'b0101100011, 10'b1011000011};
      return t[d];
   endfunction

   function automatic logic [9:0] ref_ctrl(input logic [1:0] c);
      logic [9:0] t [4];
      t = '{10'b1101010100, 10'b0010101011, 10'b0101010100, 10'b1010101011};
      return t[c];
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [9:0] act, input logic [9:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
   endtask

   task automatic check_idle(input string req);
      chk(req, "busy idle", {9'd0, busy}, 10'd0);
      chk(req, "red idle", lane_r, 10'b1101010100);
      chk(req, "green idle", lane_g, 10'b1101010100);
      chk("R8", "blue idle ctrl", lane_b, ref_ctrl({vsync, hsync}));
   endtask

   task automatic randomize_packet(output logic [63:0] h, output logic [511:0] b);
      h = {$urandom, $urandom};
      for (int w = 0; w < 16; w++) b[w*32 +: 32] = $urandom;
   endtask

   task automatic expect_pixel(input int i);
      chk("R6", "busy in island", {9'd0, busy}, 10'd1);
      if (i < 8) begin
         chk("R2", "red preamble", lane_r, 10'b0010101011);
         chk("R2", "green preamble", lane_g, 10'b0010101011);
         chk("R2 R8", "blue preamble", lane_b, ref_ctrl({vsync, hsync}));
      end else if (i < 10 || i >= 74) begin
         chk(i < 10 ? "R3" : "R6", "red guard", lane_r, 10'b0100110011);
         chk(i < 10 ? "R3" : "R6", "green guard", lane_g, 10'b0100110011);
         chk("R3 R8", "blue guard", lane_b, ref_terc4({2'b11, vsync, hsync}));
      end else begin
         int j, p, k, bg, br;
         logic [3:0] ng, nr;
         j  = i - 10;
         p  = j / 32;
         k  = j % 32;
         bg = p * 256;
         br = p * 256 + 128;
         ng = {exp_body[bg+64+2*k+1], exp_body[bg+64+2*k],
               exp_body[bg+2*k+1], exp_body[bg+2*k]};
         nr = {exp_body[br+64+2*k+1], exp_body[br+64+2*k],
               exp_body[br+2*k+1], exp_body[br+2*k]};
         chk("R4 R8 R10", "blue data", lane_b,
             ref_terc4({k != 0, exp_hdr[p*32+k], vsync, hsync}));
         chk("R5 R9 R10", "green data", lane_g, ref_terc4(ng));
         chk("R5 R9 R10", "red data", lane_r, ref_terc4(nr));
      end
   endtask

   // one negedge per pixel; new syncs and new source data every pixel
   task automatic island_pixels();
      logic [63:0]  h;
      logic [511:0] b;
      for (int i = 0; i < ISL; i++) begin
         @(negedge clk);
         island_req = 1'b0;
         randomize_packet(h, b);
         pkt_header = h;
         pkt_body   = b;
         hsync      = 1'($urandom);
         vsync      = 1'($urandom);
         blank_left = 12'($urandom % 200);
         #1;
         expect_pixel(i);
      end
      @(negedge clk);
      #1;
      check_idle("R6");
   endtask

   task automatic run_island(input bit corner);
      logic [63:0]  h;
      logic [511:0] b;
      @(negedge clk);
      randomize_packet(h, b);
      if (corner) begin
         h = 64'hFFFF_FFFF_0000_0001;
         b = {256'd0, {256{1'b1}}};
      end
      pkt_header = h;
      pkt_body   = b;
      exp_hdr    = h;
      exp_body   = b;
      island_req = 1'b1;
      hsync      = 1'($urandom);
      vsync      = 1'($urandom);
      blank_left = corner ? 12'(ISL) : 12'(ISL + ($urandom % 60));
      #1;
      check_idle("R1");
      island_pixels();
   endtask

   task automatic deferred_island();
      logic [63:0]  h;
      logic [511:0] b;
      @(negedge clk);
      island_req = 1'b1;
      blank_left = 12'(ISL - 1);
      for (int c = 0; c < 5; c++) begin
         @(negedge clk);
         island_req = 1'b0;
         hsync      = 1'($urandom);
         vsync      = 1'($urandom);
         #1;
         chk("R7", "held without room", {9'd0, busy}, 10'd0);
      end
      @(negedge clk);
      randomize_packet(h, b);
      pkt_header = h;
      pkt_body   = b;
      exp_hdr    = h;
      exp_body   = b;
      blank_left = 12'(ISL);
      #1;
      chk("R7", "not yet launched", {9'd0, busy}, 10'd0);
      island_pixels();
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         done = 1'b1;
         n_checks++;
         n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4321));
      #1;
      check_idle("R1");
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      check_idle("R1");
      // control symbols on blue for all sync pairs while idle
      for (int s = 0; s < 4; s++) begin
         @(negedge clk);
         {vsync, hsync} = 2'(s);
         #1;
         check_idle("R1");
      end
      run_island(1'b1);
      deferred_island();
      for (int n = 0; n < NRAND; n++) run_island(1'b0);
      repeat (3) @(negedge clk);
      #1;
      check_idle("R1");
      done = 1'b1;
      summary();
      $finish;
   end

endmodule